// File: doc/BRIEF.md
# Half-Width Slave Adapter for a 64-bit Data Bus

This wrapper places an unmodified slave with a 32-bit data port on a 64-bit AHB-style data bus. Address and control pass straight through to the slave. The adapter remembers which 32-bit half of the wide bus the current transfer targets, and uses that choice in the data phase to steer write data to the slave and to place the slave's read data on the wide bus.

The adapter has two read-data styles, chosen by a parameter. The first style copies the slave's word onto every half of the wide read bus. The second style drives only the addressed half and keeps the other half at its last value, which reduces toggling.

The slave cannot carry a transfer wider than its own port. The adapter therefore keeps any such transfer away from the slave and answers it with a two-cycle ERROR response.

Top module: `wide_bus_slave_adapter`

## Requirements
- R1: `s_addr`, `s_trans`, `s_write`, `s_size` and `s_ready` equal `m_addr`, `m_trans`, `m_write`, `m_size` and `m_ready` in the same cycle. `s_sel` equals `m_sel` for every transfer that R6 does not block.
- R2: The half select is address bit 2. It is registered on the rising clock edge only when `m_ready` is 1, so a cycle with `m_ready` at 0 leaves the previous selection in place. The half select resets to 0 (the lower half).
- R3: In the data phase, `s_wdata` is `m_wdata[63:32]` when the registered select is 1 and `m_wdata[31:0]` when it is 0.
- R4: With `REPLICATE`=1, both `m_rdata[63:32]` and `m_rdata[31:0]` equal `s_rdata` in the same cycle.
- R5: With `REPLICATE`=0, the half picked by the registered select shows `s_rdata` in the same cycle. The other half keeps the value it last showed.
- R6: An address phase with `m_sel`=1, `m_trans[1]`=1, `m_ready`=1 and `m_size` greater than 2 (a transfer wider than 32 bits) is oversized, and `s_sel` is 0 in that cycle. A `m_size` of 2 or less is never blocked.
- R7: One cycle after an oversized address phase, the adapter drives `m_resp`=1 and `m_readyout`=0. In the cycle after that it drives `m_resp`=1 and `m_readyout`=1. A transfer of 32 bits or less produces no error.
- R8: When no error sequence is running, `m_readyout` equals `s_readyout` and `m_resp` equals `s_resp`.
- R9: After an active-low reset, the half select, the held read data and the error state are all zero. With the slave ready, `m_readyout` is 1 and `m_resp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| m_sel | input | 1 | Slave select from the wide bus |
| m_addr | input | AW | Transfer address |
| m_trans | input | 2 | Transfer type |
| m_write | input | 1 | 1 = write |
| m_size | input | 3 | Transfer size, log2 of bytes |
| m_ready | input | 1 | Bus-wide ready (the previous transfer is complete) |
| m_wdata | input | BUS_W | Wide write data |
| m_rdata | output | BUS_W | Wide read data |
| m_readyout | output | 1 | Ready returned to the bus |
| m_resp | output | 1 | Response returned to the bus, 1 = ERROR |
| s_sel | output | 1 | Select to the slave, blocked for oversized transfers |
| s_addr | output | AW | Address to the slave |
| s_trans | output | 2 | Transfer type to the slave |
| s_write | output | 1 | Write flag to the slave |
| s_size | output | 3 | Size to the slave |
| s_ready | output | 1 | Bus ready to the slave |
| s_wdata | output | SLV_W | Write data to the slave |
| s_rdata | input | SLV_W | Read data from the slave |
| s_readyout | input | 1 | Ready from the slave |
| s_resp | input | 1 | Response from the slave |

## Verification
The adapter's results fall due at three different delays:
- **Same cycle:** selects, control pass-through, replicated read data and response pass-through appear in the cycle of their stimulus.
- **One cycle later:** write steering and the lane-gated read data follow the address phase by one cycle, because the half select is registered.
- **One and two cycles later:** the two ERROR cycles appear one and two cycles after the oversized address phase.

The bench drives inputs just after each rising edge and queues each expected value tagged with the cycle in which it is due. The monitor compares each value at the falling edge of that cycle, so every check samples after all registers on the path have updated.

// File: rtl/wide_bus_slave_adapter.sv
module wide_bus_slave_adapter #(
  parameter int AW        = 32,
  parameter int BUS_W     = 64,
  parameter int SLV_W     = 32,
  parameter bit REPLICATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_sel,
  input  logic [AW-1:0]    m_addr,
  input  logic [1:0]       m_trans,
  input  logic             m_write,
  input  logic [2:0]       m_size,
  input  logic             m_ready,
  input  logic [BUS_W-1:0] m_wdata,
  output logic [BUS_W-1:0] m_rdata,
  output logic             m_readyout,
  output logic             m_resp,
  output logic             s_sel,
  output logic [AW-1:0]    s_addr,
  output logic [1:0]       s_trans,
  output logic             s_write,
  output logic [2:0]       s_size,
  output logic             s_ready,
  output logic [SLV_W-1:0] s_wdata,
  input  logic [SLV_W-1:0] s_rdata,
  input  logic             s_readyout,
  input  logic             s_resp
);
  localparam int LANES    = BUS_W / SLV_W;
  localparam int LSB      = $clog2(SLV_W / 8);
  localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int MAX_SIZE = LSB;

  logic [LW-1:0]    lane_q;
  logic             err1_q, err2_q;
  logic             oversize, err_hit;
  logic [SLV_W-1:0] wlane [LANES];

  assign oversize = m_size > 3'(MAX_SIZE);
  assign err_hit  = m_sel & m_trans[1] & m_ready & oversize;

  assign s_sel   = m_sel & ~err_hit;
  assign s_addr  = m_addr;
  assign s_trans = m_trans;
  assign s_write = m_write;
  assign s_size  = m_size;
  assign s_ready = m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      err1_q <= 1'b0;
      err2_q <= 1'b0;
    end else begin
      if (m_ready) lane_q <= m_addr[LSB +: LW];
      err1_q <= err_hit;
      err2_q <= err1_q;
    end
  end

  assign m_readyout = err1_q ? 1'b0 : (err2_q ? 1'b1 : s_readyout);
  assign m_resp     = err1_q | err2_q | s_resp;

  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    assign wlane[i] = m_wdata[i*SLV_W +: SLV_W];
  end
  assign s_wdata = wlane[lane_q];

  if (REPLICATE) begin : g_rep
    assign m_rdata = {LANES{s_rdata}};
  end else begin : g_gate
    logic [BUS_W-1:0] rd_hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_hold <= '0;
      else        rd_hold <= m_rdata;
    end
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign m_rdata[i*SLV_W +: SLV_W] =
        (lane_q == LW'(i)) ? s_rdata : rd_hold[i*SLV_W +: SLV_W];
    end
  end
endmodule

// File: rtl/wide_bus_slave_adapter_chk.sv
module wide_bus_slave_adapter_chk #(
  parameter int AW        = 32,
  parameter int BUS_W     = 64,
  parameter int SLV_W     = 32,
  parameter bit REPLICATE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_sel,
  input logic [AW-1:0]    m_addr,
  input logic [1:0]       m_trans,
  input logic [2:0]       m_size,
  input logic             m_ready,
  input logic [BUS_W-1:0] m_wdata,
  input logic [BUS_W-1:0] m_rdata,
  input logic             m_readyout,
  input logic             m_resp,
  input logic             s_sel,
  input logic [SLV_W-1:0] s_wdata,
  input logic [SLV_W-1:0] s_rdata,
  input logic             s_readyout,
  input logic             s_resp
);
  localparam int LSB = $clog2(SLV_W / 8);
  logic big;
  assign big = m_sel && m_trans[1] && m_ready && (m_size > 3'(LSB));

  AST_SEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) big |-> !s_sel); // R6
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n) big |=> (m_resp && !m_readyout)); // R7
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n) big |=> ##1 (m_resp && m_readyout)); // R7
  AST_WDATA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> (s_wdata == ($past(m_addr[LSB]) ? m_wdata[SLV_W +: SLV_W] : m_wdata[SLV_W-1:0]))); // R3
  AST_RESP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(big) && !$past(big, 2)) |-> (m_readyout == s_readyout && m_resp == s_resp)); // R8

  if (REPLICATE) begin : g_rep_chk
    AST_READ_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready |-> (m_rdata[SLV_W-1:0] == s_rdata && m_rdata[SLV_W +: SLV_W] == s_rdata)); // R4
  end
endmodule

bind wide_bus_slave_adapter wide_bus_slave_adapter_chk #(
  .AW(AW), .BUS_W(BUS_W), .SLV_W(SLV_W), .REPLICATE(REPLICATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_addr(m_addr), .m_trans(m_trans),
  .m_size(m_size), .m_ready(m_ready), .m_wdata(m_wdata), .m_rdata(m_rdata),
  .m_readyout(m_readyout), .m_resp(m_resp), .s_sel(s_sel), .s_wdata(s_wdata),
  .s_rdata(s_rdata), .s_readyout(s_readyout), .s_resp(s_resp)
);

// File: tb/wide_bus_slave_adapter_tb.sv
module wide_bus_slave_adapter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_sel = 1'b0;
  logic [31:0] m_addr = '0;
  logic [1:0]  m_trans = '0;
  logic        m_write = 1'b0;
  logic [2:0]  m_size = 3'd2;
  logic        m_ready = 1'b1;
  logic [63:0] m_wdata = '0;
  logic [31:0] s_rdata = '0;
  logic        s_readyout = 1'b1;
  logic        s_resp = 1'b0;

  logic [63:0] m_rdata, g_rdata;
  logic        m_readyout, m_resp, g_readyout, g_resp;
  logic        s_sel, s_write, s_ready, g_sel, g_write, g_ready;
  logic [31:0] s_addr, s_wdata, g_addr, g_wdata;
  logic [1:0]  s_trans, g_trans;
  logic [2:0]  s_size, g_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_bus_slave_adapter #(.REPLICATE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_addr(m_addr), .m_trans(m_trans),
    .m_write(m_write), .m_size(m_size), .m_ready(m_ready), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_readyout(m_readyout), .m_resp(m_resp), .s_sel(s_sel),
    .s_addr(s_addr), .s_trans(s_trans), .s_write(s_write), .s_size(s_size),
    .s_ready(s_ready), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .s_readyout(s_readyout), .s_resp(s_resp));

  wide_bus_slave_adapter #(.REPLICATE(1'b0)) u_dut_gated (
    .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_addr(m_addr), .m_trans(m_trans),
    .m_write(m_write), .m_size(m_size), .m_ready(m_ready), .m_wdata(m_wdata),
    .m_rdata(g_rdata), .m_readyout(g_readyout), .m_resp(g_resp), .s_sel(g_sel),
    .s_addr(g_addr), .s_trans(g_trans), .s_write(g_write), .s_size(g_size),
    .s_ready(g_ready), .s_wdata(g_wdata), .s_rdata(s_rdata),
    .s_readyout(s_readyout), .s_resp(s_resp));

  typedef struct {
    int          cyc;
    int          kind;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic want(input int kind, input logic [63:0] exp, input string req);
    item_t it;
    it.cyc = cyc; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic next();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] observe(input int kind);
    case (kind)
      0: return {32'h0, s_wdata};
      1: return m_rdata;
      2: return g_rdata;
      3: return {62'h0, m_resp, m_readyout};
      4: return {63'h0, s_sel};
      5: return {32'h0, s_addr};
      default: return 64'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [63:0] got;
      it = q.pop_front();
      got = observe(it.kind);
      n_checks++;
      if (it.cyc != cyc || got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d cycle %0d: actual %h expected %h", it.req, it.kind, it.cyc, got, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    next(); rst_n = 1'b1; m_wdata = 64'h01234567_89ABCDEF;
    want(3, 64'h1, "R9"); want(2, 64'h0, "R9"); want(0, 64'h89ABCDEF, "R9");

    next(); m_sel = 1; m_addr = 32'h4; m_trans = 2'b10; m_write = 1; m_size = 3'd2;
    want(4, 64'h1, "R1"); want(5, 64'h4, "R1");

    next(); m_wdata = 64'hAAAA1111_BBBB2222; m_addr = 32'h10;
    want(0, 64'hAAAA1111, "R3");

    next(); m_wdata = 64'hCCCC3333_DDDD4444; m_sel = 0; m_trans = 2'b00;
    m_addr = 32'h4; m_ready = 0;
    want(0, 64'hDDDD4444, "R3");

    next(); m_ready = 1; m_addr = 32'h0; m_wdata = 64'hEEEE5555_FFFF6666;
    want(0, 64'hFFFF6666, "R2");

    next(); m_sel = 1; m_trans = 2'b10; m_write = 0; m_addr = 32'h0;

    next(); s_rdata = 32'h11111111; m_addr = 32'h4;
    want(2, 64'h00000000_11111111, "R5"); want(1, 64'h11111111_11111111, "R4");

    next(); s_rdata = 32'h22222222; m_sel = 0; m_trans = 2'b00; m_addr = 32'h0;
    want(2, 64'h22222222_11111111, "R5"); want(1, 64'h22222222_22222222, "R4");

    next(); s_rdata = 32'h44444444;
    want(2, 64'h22222222_44444444, "R5");

    next(); s_rdata = 32'h0; m_sel = 1; m_trans = 2'b10; m_size = 3'd3; m_write = 1;
    want(4, 64'h0, "R6");

    next(); m_sel = 0; m_trans = 2'b00; m_size = 3'd2; m_ready = 0;
    want(3, 64'h2, "R7");

    next(); m_ready = 1;
    want(3, 64'h3, "R7");

    next();
    want(3, 64'h1, "R8");

    next(); s_readyout = 0;
    want(3, 64'h0, "R8");

    next(); s_readyout = 1; s_resp = 1;
    want(3, 64'h3, "R8");

    next(); s_resp = 0; m_sel = 1; m_trans = 2'b10; m_size = 3'd2;
    want(4, 64'h1, "R6");

    next(); m_sel = 1; m_trans = 2'b00; m_size = 3'd3;
    want(3, 64'h1, "R7"); want(4, 64'h1, "R6");

    next(); m_sel = 0; m_size = 3'd2;
    want(3, 64'h1, "R7");

    repeat (3) next();
    if (q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule